// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block is a small field-configurable logic cell built from sums of products. It has eight input pins and four macrocells. Every input enters a programmable AND plane in both true and inverted form. Each macrocell also returns one feedback signal to the AND plane. Each macrocell ORs its own fixed group of four product terms. The OR result can be inverted by a polarity bit. The macrocell then presents the result either directly or through a D flip-flop, and its pin driver can be switched off.

The configuration is loaded serially through a shift chain and becomes active only when a load strobe is pulsed. The shadow chain can therefore be refilled while the block keeps running on the old pattern. Each macrocell has three modes. With its driver off, its pin becomes an extra input into the AND plane. It can drive a combinational result. It can drive a registered result, which is also fed back internally so that counters and multi-level registered logic can be built.

Top module: `pal_block`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pad_oe` and `pad_out` are all zero, the active configuration is all zero and every macrocell flip-flop is clear.
- R2: With `cfg_shift` high, the chain takes `cfg_din` on each rising edge. The bit shifted in first ends in the most significant configuration bit. The active configuration changes only on a rising edge where `cfg_load` is high, and from that edge on the outputs follow the new pattern.
- R3: The AND-plane signal index j is 0..7 for `in_pins[j]` and 8+m for the feedback of macrocell m. Product term t occupies configuration bits [t*24 +: 24]. Bit 2j connects signal j true, and bit 2j+1 connects it inverted. A term is the AND of its connected literals.
- R4: A product term with no connected literal is 0.
- R5: Macrocell m ORs product terms 4m to 4m+3, and no others.
- R6: Macrocell m uses configuration bits 384+3m (polarity: 1 inverts the OR result), 385+3m (select: 1 = registered) and 386+3m (enable).
- R7: With enable 0, `pad_oe[m]` is 0 and `pad_in[m]` is the feedback signal 8+m.
- R8: With enable 1 and select 0, `pad_oe[m]` is 1 and `pad_out[m]` shows the polarity-adjusted OR result in the same cycle. The feedback is taken from `pad_in[m]`, the pin.
- R9: With select 1, `pad_out[m]` shows the polarity-adjusted OR result captured on the previous rising edge.
- R10: With enable 1 and select 1, the feedback signal 8+m is the flip-flop output, so a macrocell can use its own state or another macrocell's state.
- R11: Shifting the chain without a load strobe leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| cfg_load | input | 1 | Copies the chain into the active configuration |
| in_pins | input | 8 | Dedicated logic inputs |
| pad_in | input | 4 | Value seen on each macrocell pin |
| pad_out | output | 4 | Value driven toward each macrocell pin |
| pad_oe | output | 4 | Pin driver enable per macrocell |

## Verification
A load strobe and a registered capture can fall on the same rising edge. At that edge the flip-flop must capture the result of the outgoing pattern, and the new pattern must appear only one edge later. The bench first settles a registered macrocell on a function whose value is 1. It then shifts in, without loading, a pattern whose function evaluates to 0, and pulses the load. It judges the registered pin at the next two negative edges: the first must still read 1 and the second must read 0.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Per-macrocell configuration field; packed order gives bit 2=en, 1=sel, 0=pol
  typedef struct packed {
    logic en;
    logic sel;
    logic pol;
  } mc_cfg_t;

  localparam int unsigned MC_CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
  parameter int unsigned CFG_W = 396
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  input  logic             load,
  output logic [CFG_W-1:0] shift_q,
  output logic [CFG_W-1:0] act_q
);
  logic [CFG_W-1:0] sh_d, sh_r;
  logic [CFG_W-1:0] act_d, act_r;

  always_comb begin
    sh_d  = sh_r;
    act_d = act_r;
    if (shift_en) sh_d = {sh_r[CFG_W-2:0], din};
    if (load)     act_d = sh_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_r  <= '0;
      act_r <= '0;
    end else begin
      sh_r  <= sh_d;
      act_r <= act_d;
    end
  end

  assign shift_q = sh_r;
  assign act_q   = act_r;
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int unsigned N_SIG  = 12,
  parameter int unsigned N_TERM = 16
) (
  input  logic [N_SIG-1:0]          sig,
  input  logic [N_TERM*2*N_SIG-1:0] mask,
  output logic [N_TERM-1:0]         term
);
  localparam int unsigned LIT_W = 2 * N_SIG;

  logic [LIT_W-1:0] lit;

  // Literal 2j is signal j, literal 2j+1 its complement
  for (genvar j = 0; j < N_SIG; j++) begin : g_lit
    assign lit[2*j]   = sig[j];
    assign lit[2*j+1] = ~sig[j];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] m;
    assign m = mask[t*LIT_W +: LIT_W];
    // an empty term yields 0 so it cannot force its sum high
    assign term[t] = (|m) & (&(~m | lit));
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int unsigned N_PT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PT-1:0] terms,
  input  mc_cfg_t         cfg,
  input  logic            pad_in,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            fb,
  output logic            res
);
  logic sum;
  logic q_d, q_r;

  always_comb begin
    sum = |terms;
    res = sum ^ cfg.pol;
    q_d = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign pad_out = cfg.sel ? q_r : res;
  assign pad_oe  = cfg.en;
  // registered driven pins feed back internally; otherwise the pin value is used
  assign fb      = (cfg.en && cfg.sel) ? q_r : pad_in;
endmodule

// File: rtl/pal_block.sv
module pal_block
  import pal_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter int unsigned N_MC = 4,
  parameter int unsigned N_PT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_shift,
  input  logic            cfg_din,
  input  logic            cfg_load,
  input  logic [N_IN-1:0] in_pins,
  input  logic [N_MC-1:0] pad_in,
  output logic [N_MC-1:0] pad_out,
  output logic [N_MC-1:0] pad_oe
);
  localparam int unsigned N_SIG = N_IN + N_MC;
  localparam int unsigned LIT_W = 2 * N_SIG;
  localparam int unsigned N_TRM = N_MC * N_PT;
  localparam int unsigned AND_W = N_TRM * LIT_W;
  localparam int unsigned CFG_W = AND_W + N_MC * MC_CFG_W;

  logic [CFG_W-1:0] shift_q, cfg_act;
  logic [N_MC-1:0]  fb, mc_res, sel_bits;
  logic [N_TRM-1:0] term_v;
  logic [N_SIG-1:0] sig;

  pal_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(cfg_shift),
    .din     (cfg_din),
    .load    (cfg_load),
    .shift_q (shift_q),
    .act_q   (cfg_act)
  );

  assign sig = {fb, in_pins};

  pal_and_plane #(.N_SIG(N_SIG), .N_TERM(N_TRM)) u_plane (
    .sig (sig),
    .mask(cfg_act[AND_W-1:0]),
    .term(term_v)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    mc_cfg_t c;
    assign c           = cfg_act[AND_W + m*MC_CFG_W +: MC_CFG_W];
    assign sel_bits[m] = c.sel;

    pal_macrocell #(.N_PT(N_PT)) u_mc (
      .clk    (clk),
      .rst_n  (rst_n),
      .terms  (term_v[m*N_PT +: N_PT]),
      .cfg    (c),
      .pad_in (pad_in[m]),
      .pad_out(pad_out[m]),
      .pad_oe (pad_oe[m]),
      .fb     (fb[m]),
      .res    (mc_res[m])
    );
  end
endmodule

// File: rtl/pal_block_chk.sv
module pal_block_chk #(
  parameter int unsigned N_MC  = 4,
  parameter int unsigned N_TRM = 16,
  parameter int unsigned LIT_W = 24,
  parameter int unsigned CFG_W = 396
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_shift,
  input logic             cfg_load,
  input logic [CFG_W-1:0] shift_q,
  input logic [CFG_W-1:0] cfg_act,
  input logic [N_TRM-1:0] term_v,
  input logic [N_MC-1:0]  sel_bits,
  input logic [N_MC-1:0]  mc_res,
  input logic [N_MC-1:0]  pad_out,
  input logic [N_MC-1:0]  pad_oe
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_act)); // R2

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(pad_oe)); // R2

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(shift_q)); // R11

  for (genvar t = 0; t < N_TRM; t++) begin : g_t
    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_act[t*LIT_W +: LIT_W] == '0) |-> !term_v[t]); // R4
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_m
    AST_REG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_bits[m]) && sel_bits[m]) |-> (pad_out[m] == $past(mc_res[m]))); // R9
  end
endmodule

bind pal_block pal_block_chk #(
  .N_MC (N_MC),
  .N_TRM(N_TRM),
  .LIT_W(LIT_W),
  .CFG_W(CFG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_shift(cfg_shift),
  .cfg_load (cfg_load),
  .shift_q  (shift_q),
  .cfg_act  (cfg_act),
  .term_v   (term_v),
  .sel_bits (sel_bits),
  .mc_res   (mc_res),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/pal_block_test.sv
module pal_block_test;
  localparam int N_IN  = 8;
  localparam int N_MC  = 4;
  localparam int L     = 2 * (N_IN + N_MC);
  localparam int AND_W = N_MC * 4 * L;
  localparam int CFG_W = AND_W + 3 * N_MC;

  // {in_pins, expected pad_out} for the all-combinational pattern
  localparam logic [11:0] VEC [0:7] = '{12'h00A, 12'h037, 12'h04B, 12'h0CA,
                                        12'h708, 12'h80E, 12'hF14, 12'h022};

  logic clk = 1'b0;
  logic rst_n, cfg_shift, cfg_din, cfg_load;
  logic [N_IN-1:0] in_pins;
  logic [N_MC-1:0] pad_in;
  wire  [N_MC-1:0] pad_out, pad_oe;
  logic [CFG_W-1:0] cfg;
  int total = 0, bad = 0;
  logic prev2;

  always #5 clk = ~clk;

  pal_block uut (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
    .cfg_load(cfg_load), .in_pins(in_pins), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_lit(input int t, input int j, input int neg);
    cfg[t*L + 2*j + neg] = 1'b1;
  endtask

  task automatic set_mc(input int m, input logic en, input logic sel, input logic pol);
    cfg[AND_W + 3*m +: 3] = {en, sel, pol};
  endtask

  task automatic shift_cfg();
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_din   = cfg[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0; cfg_load = 1'b0;
    in_pins = '0; pad_in = '0; cfg = '0;
    #23;
    check("R1 oe in reset", pad_oe, 4'h0);
    check("R1 out in reset", pad_out, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", pad_oe, 4'h0);
    check("R1 out after reset", pad_out, 4'h0);

    // Combinational pattern: f0=x0x1+x2x3', f1=~(x4x5x6), f2=x7+x7'x0, f3=x0'x1'
    cfg = '0;
    set_lit(0, 0, 0); set_lit(0, 1, 0);
    set_lit(1, 2, 0); set_lit(1, 3, 1);
    set_lit(4, 4, 0); set_lit(4, 5, 0); set_lit(4, 6, 0);
    set_lit(8, 7, 0);
    set_lit(9, 7, 1); set_lit(9, 0, 0);
    set_lit(12, 0, 1); set_lit(12, 1, 1);
    set_lit(13, 0, 0); set_lit(13, 0, 1);  // contradiction, always 0
    set_mc(0, 1, 0, 0); set_mc(1, 1, 0, 1); set_mc(2, 1, 0, 0); set_mc(3, 1, 0, 0);
    shift_cfg();
    check("R11 shifted, not loaded", pad_oe, 4'h0);
    pulse_load();
    check("R2 oe after load", pad_oe, 4'hF);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_pins = VEC[i][11:4];
      #2;
      check("R3 R5 R6 R8 table vector", pad_out, VEC[i][3:0]);
    end

    // Empty terms and polarity: all sums empty, mc1 and mc3 inverted
    cfg = '0;
    set_mc(0, 1, 0, 0); set_mc(1, 1, 0, 1); set_mc(2, 1, 0, 0); set_mc(3, 1, 0, 1);
    in_pins = 8'h00;
    shift_cfg();
    check("R11 old pattern still active", pad_out, 4'hA);
    pulse_load();
    #2; check("R4 R6 empty terms, inputs 00", pad_out, 4'hA);
    in_pins = 8'hFF;
    #2; check("R4 R6 empty terms, inputs FF", pad_out, 4'hA);

    // Pin as input: mc0 driver off, mc1 = pin0, mc2 = ~pin0
    cfg = '0;
    set_lit(4, 8, 0); set_lit(8, 8, 1);
    set_mc(0, 0, 0, 0); set_mc(1, 1, 0, 0); set_mc(2, 1, 0, 0); set_mc(3, 0, 0, 0);
    shift_cfg(); pulse_load();
    check("R7 oe pattern", pad_oe, 4'b0110);
    pad_in = 4'b0001;
    #2; check("R7 pin0 high", pad_out & 4'b0110, 4'b0010);
    pad_in = 4'b0000;
    #2; check("R7 pin0 low", pad_out & 4'b0110, 4'b0100);

    // Registered: q0 <= x0, q1 <= q0 (feedback 8), q2 <= ~q2 (feedback 10)
    cfg = '0;
    set_lit(0, 0, 0); set_lit(4, 8, 0); set_lit(8, 10, 1);
    set_mc(0, 1, 1, 0); set_mc(1, 1, 1, 0); set_mc(2, 1, 1, 0);
    in_pins = 8'h00;
    shift_cfg(); pulse_load();
    @(negedge clk); @(negedge clk);
    check("R9 settled low", pad_out & 4'b0011, 4'b0000);
    in_pins = 8'h01;
    #2; check("R9 not before edge", pad_out & 4'b0011, 4'b0000);
    @(negedge clk);
    check("R9 captured after one edge", pad_out & 4'b0011, 4'b0001);
    prev2 = pad_out[2];
    @(negedge clk);
    check("R10 second stage follows first", pad_out & 4'b0011, 4'b0011);
    check("R10 self feedback toggles", {3'b000, pad_out[2]}, {3'b000, ~prev2});
    prev2 = pad_out[2];
    @(negedge clk);
    check("R10 self feedback toggles again", {3'b000, pad_out[2]}, {3'b000, ~prev2});

    // Load and capture on the same edge: old function 1, new function ~x0 = 0
    cfg = '0;
    set_lit(0, 0, 1);
    set_mc(0, 1, 1, 0);
    shift_cfg();
    check("R11 registered out unchanged by shift", {3'b000, pad_out[0]}, 4'h1);
    pulse_load();
    check("R2 edge of load keeps old capture", {3'b000, pad_out[0]}, 4'h1);
    @(negedge clk);
    check("R2 new pattern one edge later", {3'b000, pad_out[0]}, 4'h0);

    // Reset in mid-run clears drivers and flops
    rst_n = 1'b0;
    #2;
    check("R1 oe on mid-run reset", pad_oe, 4'h0);
    check("R1 out on mid-run reset", pad_out, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 configuration cleared", pad_oe, 4'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule